// File: doc/BRIEF.md
# PCI Target Parity Unit

This block covers the parity duties of a PCI target. It watches every transaction's address phase and compares the PAR line against the even parity of the bus one clock later. A mismatch pulls the open-drain system-error line low for one clock. For each write data phase that completes at this target, the block records the parity of the sampled data and byte enables. One clock later it compares that against PAR, and the clock after that it drives the data-parity-error line low. For each read data phase in which the target drives the bus, the block produces PAR and its output enable one clock after the target-ready handshake.

The configuration enables and the selection, direction and special-cycle flags come from the surrounding target logic as plain inputs. Two one-clock event pulses let an external status register record detected data parity errors and signalled system errors. The asynchronous reset is released through a short synchronizer. While reset is held, every output is idle: nothing is driven and the error lines are released.

Top module: `pcipar_unit`

## Requirements
- R1: PAR produced by the block makes the total number of ones across AD[31:0], C/BE#[3:0] and PAR even.
- R2: `par_oe_o` is high in the clock after an edge where TRDY# is low, the target is selected, the transaction is a read and `io_en_i` is set. `par_o` then carries the parity of the AD and C/BE# values sampled at that edge. In every other case `par_oe_o` is low.
- R3: An address phase is an edge where FRAME# is sampled low after being high at the previous edge. If PAR sampled at the next edge differs from the parity of that address and command, and `serr_en_i` is set at that edge, `serr_pull_o` is 1 for exactly the following clock.
- R4: `serr_evt_o` pulses for one clock exactly when `serr_pull_o` pulls low. Neither output is ever active while `serr_en_i` was clear at the comparing edge.
- R5: A write data phase completes at an edge where IRDY# and TRDY# are both low, the target is selected and the transaction is a write. If PAR at the next edge mismatches and `perr_en_i` is set, `perr_n_o` is 0 for the clock that follows that edge.
- R6: A phase that is not completed, is a read, or is not at this target causes no data parity report, even with wrong PAR.
- R7: When the special-cycle flag is set at the completing edge, no data parity error is reported and no detect pulse is produced.
- R8: `dperr_evt_o` pulses for one clock on every data parity mismatch of a completed non-special write, whether or not `perr_en_i` is set.
- R9: `perr_oe_o` is high while `perr_n_o` is low and for one further clock in which `perr_n_o` is driven high, and is low otherwise.
- R10: While reset is asserted, and for two clocks after its release, all drive enables, `serr_pull_o` and both event pulses are 0 and `perr_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Sampled address/data bus |
| cbe_n_i | input | 4 | Sampled command / byte enables (active low) |
| frame_n_i | input | 1 | FRAME# as sampled |
| irdy_n_i | input | 1 | IRDY# as sampled |
| trdy_n_i | input | 1 | TRDY# as sampled |
| par_i | input | 1 | PAR as sampled |
| tgt_sel_i | input | 1 | This target owns the current transaction |
| rd_i | input | 1 | 1 = read transaction, 0 = write |
| special_i | input | 1 | Current transaction is a special cycle |
| io_en_i | input | 1 | Target response enable, gates PAR drive |
| perr_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | System error enable |
| par_o | output | 1 | Generated PAR value |
| par_oe_o | output | 1 | PAR output enable |
| perr_n_o | output | 1 | PERR# drive value |
| perr_oe_o | output | 1 | PERR# output enable |
| serr_pull_o | output | 1 | 1 = pull SERR# low, 0 = release |
| dperr_evt_o | output | 1 | One-clock pulse: data parity error detected |
| serr_evt_o | output | 1 | One-clock pulse: system error signalled |

## Verification
The three paths each keep one clock of pending state: the latched parity and a pending flag. A pending flag that is lost or stuck shows as a missing or spurious pulse on `serr_pull_o` or `perr_n_o` exactly two clocks after the qualifying edge. A wrong latched parity value shows on `par_o` one clock after TRDY#, or as a report with correct PAR, in that same two-clock window. A stuck PERR# hold register shows as `perr_oe_o` staying high or dropping early on the clock after a report. The sweeps inject good and bad PAR under every enable and flag combination, so each fault class shows up within three clocks of the stimulus that exercises it.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;
  localparam int unsigned PCI_AD_W   = 32;
  localparam int unsigned PCI_BE_W   = 4;
  localparam int unsigned RST_STAGES = 2;

  // One clock of pending parity comparison
  typedef struct packed {
    logic pend;   // a comparison is due at the next edge
    logic calc;   // parity computed from the sampled bus
    logic spec;   // phase belonged to a special cycle
  } chk_t;

  localparam chk_t CHK_IDLE = '{pend: 1'b0, calc: 1'b0, spec: 1'b0};
endpackage

// File: rtl/pcipar_rst_sync.sv
module pcipar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/pcipar_rd_gen.sv
module pcipar_rd_gen
  import pcipar_pkg::*;
#(
  parameter int unsigned AD_W = PCI_AD_W,
  parameter int unsigned BE_W = PCI_BE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            trdy_n_i,
  input  logic            tgt_sel_i,
  input  logic            rd_i,
  input  logic            io_en_i,
  output logic            par_o,
  output logic            par_oe_o
);
  logic drive;
  logic par_d, oe_d;
  logic par_q, oe_q;

  always_comb begin
    drive = !trdy_n_i && tgt_sel_i && rd_i && io_en_i;
    oe_d  = drive;
    par_d = ^{ad_i, cbe_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      par_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
      if (drive) par_q <= par_d;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

  assert_par_oe_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> $past(!trdy_n_i && rd_i && tgt_sel_i && io_en_i));
  assert_par_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> ($countones({$past(ad_i), $past(cbe_n_i), par_o}) % 2 == 0));
endmodule

// File: rtl/pcipar_addr_chk.sv
module pcipar_addr_chk
  import pcipar_pkg::*;
#(
  parameter int unsigned AD_W = PCI_AD_W,
  parameter int unsigned BE_W = PCI_BE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            frame_n_i,
  input  logic            par_i,
  input  logic            serr_en_i,
  output logic            serr_pull_o,
  output logic            serr_evt_o
);
  logic frame_q;
  chk_t pend_d, pend_q;
  logic mism, serr_d, serr_q;

  always_comb begin
    pend_d.pend = !frame_n_i && frame_q;
    pend_d.calc = ^{ad_i, cbe_n_i};
    pend_d.spec = 1'b0;
    mism        = pend_q.pend && (pend_q.calc != par_i);
    serr_d      = mism && serr_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      pend_q  <= CHK_IDLE;
      serr_q  <= 1'b0;
    end else begin
      frame_q <= frame_n_i;
      pend_q  <= pend_d;
      serr_q  <= serr_d;
    end
  end

  assign serr_pull_o = serr_q;
  assign serr_evt_o  = serr_q;

  assert_serr_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pull_o |-> $past(serr_en_i));
  assert_serr_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pull_o |-> $past(!frame_n_i, 2));
endmodule

// File: rtl/pcipar_data_chk.sv
module pcipar_data_chk
  import pcipar_pkg::*;
#(
  parameter int unsigned AD_W = PCI_AD_W,
  parameter int unsigned BE_W = PCI_BE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            irdy_n_i,
  input  logic            trdy_n_i,
  input  logic            tgt_sel_i,
  input  logic            rd_i,
  input  logic            special_i,
  input  logic            par_i,
  input  logic            perr_en_i,
  output logic            perr_n_o,
  output logic            perr_oe_o,
  output logic            dperr_evt_o
);
  chk_t pend_d, pend_q;
  logic mism;
  logic perr_d, perr_q;
  logic hold_d, hold_q;
  logic evt_d, evt_q;

  always_comb begin
    pend_d.pend = !irdy_n_i && !trdy_n_i && tgt_sel_i && !rd_i;
    pend_d.calc = ^{ad_i, cbe_n_i};
    pend_d.spec = special_i;
    mism        = pend_q.pend && !pend_q.spec && (pend_q.calc != par_i);
    evt_d       = mism;
    perr_d      = mism && perr_en_i;
    hold_d      = perr_q && !perr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= CHK_IDLE;
      perr_q <= 1'b0;
      hold_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      perr_q <= perr_d;
      hold_q <= hold_d;
      evt_q  <= evt_d;
    end
  end

  assign perr_n_o    = !perr_q;
  assign perr_oe_o   = perr_q || hold_q;
  assign dperr_evt_o = evt_q;

  assert_perr_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(perr_en_i));
  assert_perr_completed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(!irdy_n_i && !trdy_n_i && tgt_sel_i && !rd_i, 2));
  assert_perr_not_special_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dperr_evt_o |-> !$past(special_i, 2));
  assert_perr_release_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_oe_o) |-> $past(perr_n_o));
endmodule

// File: rtl/pcipar_unit.sv
module pcipar_unit
  import pcipar_pkg::*;
#(
  parameter int unsigned AD_W = PCI_AD_W,
  parameter int unsigned BE_W = PCI_BE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            frame_n_i,
  input  logic            irdy_n_i,
  input  logic            trdy_n_i,
  input  logic            par_i,
  input  logic            tgt_sel_i,
  input  logic            rd_i,
  input  logic            special_i,
  input  logic            io_en_i,
  input  logic            perr_en_i,
  input  logic            serr_en_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            perr_n_o,
  output logic            perr_oe_o,
  output logic            serr_pull_o,
  output logic            dperr_evt_o,
  output logic            serr_evt_o
);
  logic rst_n_s;

  pcipar_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  pcipar_rd_gen #(.AD_W(AD_W), .BE_W(BE_W)) rd_gen_i (
    .clk(clk), .rst_n(rst_n_s), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .trdy_n_i(trdy_n_i), .tgt_sel_i(tgt_sel_i), .rd_i(rd_i),
    .io_en_i(io_en_i), .par_o(par_o), .par_oe_o(par_oe_o)
  );

  pcipar_addr_chk #(.AD_W(AD_W), .BE_W(BE_W)) addr_chk_i (
    .clk(clk), .rst_n(rst_n_s), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .frame_n_i(frame_n_i), .par_i(par_i), .serr_en_i(serr_en_i),
    .serr_pull_o(serr_pull_o), .serr_evt_o(serr_evt_o)
  );

  pcipar_data_chk #(.AD_W(AD_W), .BE_W(BE_W)) data_chk_i (
    .clk(clk), .rst_n(rst_n_s), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i), .tgt_sel_i(tgt_sel_i),
    .rd_i(rd_i), .special_i(special_i), .par_i(par_i),
    .perr_en_i(perr_en_i), .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
    .dperr_evt_o(dperr_evt_o)
  );

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n_s |=> !(par_oe_o || perr_oe_o || serr_pull_o || dperr_evt_o || serr_evt_o) || !rst_n_s);
  assert_serr_evt_pair_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    serr_evt_o |-> (serr_pull_o && $past(serr_en_i)));
endmodule

// File: tb/pcipar_unit_tb_top.sv
module pcipar_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        frame_n, irdy_n, trdy_n, par_in;
  logic        tgt_sel, rd, special, io_en, perr_en, serr_en;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o, serr_pull_o, dperr_evt_o, serr_evt_o;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1badf00d;

  always #2 clk = ~clk;

  pcipar_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .par_i(par_in),
    .tgt_sel_i(tgt_sel), .rd_i(rd), .special_i(special), .io_en_i(io_en),
    .perr_en_i(perr_en), .serr_en_i(serr_en),
    .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
    .serr_pull_o(serr_pull_o), .dperr_evt_o(dperr_evt_o), .serr_evt_o(serr_evt_o)
  );

  function automatic logic even_bit(input logic [31:0] a, input logic [3:0] b);
    int cnt = 0;
    for (int k = 0; k < 32; k++) cnt += int'(a[k]);
    for (int k = 0; k < 4; k++) cnt += int'(b[k]);
    return logic'(cnt % 2);
  endfunction

  function automatic logic [31:0] next_pat(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; tgt_sel = 1'b0;
    rd = 1'b0; special = 1'b0; par_in = 1'b0; ad = '0; cbe_n = 4'hf;
  endtask

  task automatic outs_idle(input string req);
    chk(req, {par_oe_o, perr_oe_o, perr_n_o, serr_pull_o, dperr_evt_o, serr_evt_o}, 6'b001000);
  endtask

  function automatic logic [31:0] pick(input int i);
    if (i == 0) return 32'h0;
    if (i == 1) return 32'hffff_ffff;
    if (i < 34) return 32'h1 << (i - 2);
    return seed;
  endfunction

  // R1 R2: read phase parity generation
  task automatic rd_phase(input logic [31:0] d, input logic [3:0] be, input logic sel, input logic en);
    @(negedge clk);
    idle(); io_en = en; tgt_sel = sel; rd = 1'b1; trdy_n = 1'b0; irdy_n = 1'b0;
    ad = d; cbe_n = be;
    @(negedge clk);
    idle();
    chk("R2 par_oe", {31'd0, par_oe_o}, {31'd0, sel & en});
    if (sel & en) chk("R1 par value", {31'd0, par_o}, {31'd0, even_bit(d, be)});
    @(negedge clk);
    chk("R2 par_oe released", {31'd0, par_oe_o}, 32'd0);
  endtask

  // R5..R9: write data phase check
  task automatic wr_phase(input logic [31:0] d, input logic [3:0] be, input logic flip,
                          input logic en, input logic spec, input logic done,
                          input logic sel, input logic rdir);
    logic rep, det;
    det = flip & !spec & done & sel & !rdir;
    rep = det & en;
    @(negedge clk);
    idle(); perr_en = en; tgt_sel = sel; rd = rdir; special = spec;
    irdy_n = 1'b0; trdy_n = !done; ad = d; cbe_n = be;
    @(negedge clk);
    idle(); par_in = even_bit(d, be) ^ flip;
    @(negedge clk);
    par_in = 1'b0;
    if (spec) chk("R7 perr special", {30'd0, perr_n_o, dperr_evt_o}, {30'd0, 1'b1, 1'b0});
    else if (!(done & sel & !rdir)) chk("R6 no check", {30'd0, perr_n_o, dperr_evt_o}, {30'd0, 1'b1, 1'b0});
    else begin
      chk("R5 perr_n", {31'd0, perr_n_o}, {31'd0, !rep});
      chk("R8 dperr_evt", {31'd0, dperr_evt_o}, {31'd0, det});
    end
    chk("R9 perr_oe asserted", {31'd0, perr_oe_o}, {31'd0, rep});
    @(negedge clk);
    chk("R9 perr_oe hold", {30'd0, perr_oe_o, perr_n_o}, {30'd0, rep, 1'b1});
    chk("R8 dperr_evt one clock", {31'd0, dperr_evt_o}, 32'd0);
    @(negedge clk);
    chk("R9 perr_oe released", {31'd0, perr_oe_o}, 32'd0);
  endtask

  // R3 R4: address phase check
  task automatic addr_phase(input logic [31:0] a, input logic [3:0] cmd, input logic flip, input logic en);
    logic exp;
    exp = flip & en;
    @(negedge clk);
    idle(); serr_en = en;
    @(negedge clk);
    frame_n = 1'b0; ad = a; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1'b1; ad = '0; cbe_n = 4'hf; par_in = even_bit(a, cmd) ^ flip;
    @(negedge clk);
    par_in = 1'b0;
    chk("R3 serr_pull", {31'd0, serr_pull_o}, {31'd0, exp});
    chk("R4 serr_evt", {31'd0, serr_evt_o}, {31'd0, exp});
    @(negedge clk);
    chk("R3 serr one clock", {30'd0, serr_pull_o, serr_evt_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(); io_en = 1'b1; perr_en = 1'b1; serr_en = 1'b1;
    rst_n = 1'b0;
    // R10: drive stimulus that would otherwise trigger every path
    repeat (3) @(negedge clk);
    outs_idle("R10 in reset");
    rd = 1'b1; tgt_sel = 1'b1; trdy_n = 1'b0;
    @(negedge clk);
    outs_idle("R10 in reset with read");
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    outs_idle("R10 sync release 1");
    @(negedge clk);
    outs_idle("R10 sync release 2");
    repeat (2) @(negedge clk);

    for (int i = 0; i < 48; i++) begin
      seed = next_pat(seed);
      rd_phase(pick(i), seed[3:0], 1'b1, 1'b1);
    end
    rd_phase(32'h1234_5678, 4'h0, 1'b0, 1'b1);
    rd_phase(32'h1234_5678, 4'h0, 1'b1, 1'b0);

    for (int i = 0; i < 32; i++) begin
      seed = next_pat(seed);
      wr_phase(pick(i + 2), seed[3:0], logic'(i % 2), logic'((i / 2) % 2),
               logic'(i % 8 == 7), 1'b1, 1'b1, 1'b0);
    end
    wr_phase(32'hdead_beef, 4'h5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    wr_phase(32'hdead_beef, 4'h5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    wr_phase(32'hdead_beef, 4'h5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    wr_phase(32'h0000_0001, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

    for (int i = 0; i < 32; i++) begin
      seed = next_pat(seed);
      addr_phase(pick(i), seed[7:4], logic'(i % 2), logic'((i / 2) % 2));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule